// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers interrupt conditions for a storage controller that masters its own bus. Conditions fall into two groups. Link-side events land in two 8-bit status registers and DMA-side events land in one 7-bit status register. Each condition bit has its own enable bit. A summary register reports, one bit per group, whether any enabled condition is pending. It also holds an on-the-fly flag. An active-low request pin tells the host that service is needed.

The host services the block through a simple register port. Reading the summary register has no side effect. Reading a group status register returns its contents and clears them. The on-the-fly flag clears only when a one is written to it. While the embedded sequencer runs, only the summary register can be reached. All other reads return zero and all other writes are dropped.

A link condition marked fatal that arrives during a receive transfer does not raise the request until the DMA FIFO reports empty. The DMA status register also carries a live FIFO-empty bit that is never cleared and never interrupts. Two control writes produce one-cycle clear pulses for the DMA FIFO and for the link FIFO. The register port carries no data stream, so every pin is plain control or status with no valid/ready handshake.

Top module: `irq_status_ctrl`

## Requirements
- R1: The summary register sits at address 0. Bit 0 is link-pending, bit 1 is DMA-pending and bit 2 is the on-the-fly flag. Both pending bits can be set at once, and `irq_n` is low whenever any of the three bits is set.
- R2: A pulse on `onfly_evt` sets the on-the-fly flag. Reads do not clear it. Only a write to address 0 with bit 2 at one clears it. If an event arrives in the same cycle as that write, the flag stays set.
- R3: Link conditions 7..0 appear at address 1 and conditions 15..8 at address 2, with condition n at bit n mod 8. A read returns the latched value and clears it. Link-pending drops once no enabled link condition remains.
- R4: DMA conditions 6..0 appear in bits 6..0 of address 3, and a read clears them. Bit 7 of that read is the live `dma_fifo_empty` input. It is never cleared and never sets DMA-pending. DMA conditions raise the request whatever the FIFO state.
- R5: The enable registers are read/write. Address 4 holds link enables 7..0, address 5 holds link enables 15..8 and address 6 holds DMA enables 6..0, and all reset to zero. A masked condition still latches in its status register but sets neither its pending bit nor `irq_n`.
- R6: A condition arriving in the same cycle as a clearing read of its register stays set after that read. The read itself returns the value held before the event.
- R7: While `seq_active` is high, only address 0 responds. Reads of other addresses return zero and clear nothing, and writes to other addresses are ignored.
- R8: A link condition selected by `FATAL_MASK` can arrive while `rx_dir` is high and `dma_fifo_empty` is low. In that case link-pending and the request stay low until `dma_fifo_empty` goes high. With `rx_dir` low, or for a non-fatal condition, the request rises in the next cycle.
- R9: Writing address 7 with bit 2 at one gives a one-cycle pulse on `dma_fifo_clr` in the next cycle. Writing address 8 with bit 1 at one gives a one-cycle pulse on `link_fifo_clr`.
- R10: `reg_rdata` shows the read value in the cycle after `reg_rd` and is zero in every other cycle. After reset, all status and enable bits are clear and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_evt | input | 16 | Link condition pulses, one bit per condition |
| dma_evt | input | 7 | DMA condition pulses |
| onfly_evt | input | 1 | On-the-fly interrupt pulse |
| rx_dir | input | 1 | High during a receive transfer |
| dma_fifo_empty | input | 1 | DMA FIFO has drained |
| seq_active | input | 1 | Embedded sequencer running; only the summary register is accessible |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after `reg_rd` |
| irq_n | output | 1 | Active-low interrupt request |
| dma_fifo_clr | output | 1 | One-cycle DMA FIFO clear pulse |
| link_fifo_clr | output | 1 | One-cycle link FIFO clear pulse |

## Verification
Every link and DMA condition is fired alone, once with its enable set and once masked. The bench compares the summary bits, the request pin and two back-to-back reads against values it computes from the bit index. This separates a latched-but-masked condition from an interrupting one, and checks that the clear-on-read logic hits only the addressed bits. DMA conditions are swept with the FIFO-empty input alternating, which shows that bit 7 is live, survives reads and never interrupts. Separate patterns cover:
- a fatal receive-side event with the FIFO still full;
- the same event with `rx_dir` low;
- an event coinciding with a clearing read or write;
- accesses while the sequencer is active.

Each of these must produce a different request timing or a different readback.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef logic [3:0] addr_t;

  localparam addr_t A_SUM  = 4'd0;
  localparam addr_t A_LS0  = 4'd1;
  localparam addr_t A_DST  = 4'd3;
  localparam addr_t A_LEN0 = 4'd4;
  localparam addr_t A_DEN  = 4'd6;
  localparam addr_t A_DCTL = 4'd7;
  localparam addr_t A_LCTL = 4'd8;

  localparam int SUM_LINK = 0;
  localparam int SUM_DMA  = 1;
  localparam int SUM_FLY  = 2;
  localparam int DCLR_BIT = 2;
  localparam int LCLR_BIT = 1;
endpackage

// File: rtl/isc_stat_reg.sv
// One condition group: sticky status with clear-on-read, plus its enable mask.
module isc_stat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] en,
  output logic         pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      // A new event wins over a clearing read in the same cycle.
      stat <= (rd_clr ? '0 : stat) | evt;
      if (en_we) en <= en_wdata;
    end
  end

  assign pend = |(stat & en);
endmodule

// File: rtl/isc_drain_gate.sv
// Holds link interrupts back while a fatal receive-side event waits for the DMA FIFO to drain.
module isc_drain_gate #(
  parameter int          W     = 16,
  parameter logic [W-1:0] FATAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rx_dir,
  input  logic         fifo_empty,
  output logic         hold
);
  logic fatal_hit;
  assign fatal_hit = |(evt & FATAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= (hold | (fatal_hit & rx_dir)) & !fifo_empty;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LINK_REGS = 2,
  parameter int DMA_W     = 7,
  parameter logic [DW*LINK_REGS-1:0] FATAL_MASK = 16'h0003
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DW*LINK_REGS-1:0]   link_evt,
  input  logic [DMA_W-1:0]          dma_evt,
  input  logic                      onfly_evt,
  input  logic                      rx_dir,
  input  logic                      dma_fifo_empty,
  input  logic                      seq_active,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic [3:0]                reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  output logic                      irq_n,
  output logic                      dma_fifo_clr,
  output logic                      link_fifo_clr
);
  localparam int LINK_W = DW * LINK_REGS;

  // While the sequencer runs, only the summary register is reachable.
  logic host_ok, rd_ok, wr_ok;
  assign host_ok = !seq_active || (reg_addr == A_SUM);
  assign rd_ok   = reg_rd && host_ok;
  assign wr_ok   = reg_wr && host_ok;

  logic [LINK_REGS-1:0][DW-1:0] lstat, len;
  logic [LINK_REGS-1:0]         lpend;

  for (genvar g = 0; g < LINK_REGS; g++) begin : g_link
    localparam addr_t A_ST = addr_t'(A_LS0 + g);
    localparam addr_t A_EN = addr_t'(A_LEN0 + g);
    isc_stat_reg #(.W(DW)) u_lreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (link_evt[g*DW +: DW]),
      .rd_clr   (rd_ok && reg_addr == A_ST),
      .en_we    (wr_ok && reg_addr == A_EN),
      .en_wdata (reg_wdata),
      .stat     (lstat[g]),
      .en       (len[g]),
      .pend     (lpend[g])
    );
  end

  logic [DMA_W-1:0] dstat, den;
  logic             dpend;
  isc_stat_reg #(.W(DMA_W)) u_dreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (dma_evt),
    .rd_clr   (rd_ok && reg_addr == A_DST),
    .en_we    (wr_ok && reg_addr == A_DEN),
    .en_wdata (reg_wdata[DMA_W-1:0]),
    .stat     (dstat),
    .en       (den),
    .pend     (dpend)
  );

  logic drain_hold;
  isc_drain_gate #(.W(LINK_W), .FATAL(FATAL_MASK)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (link_evt),
    .rx_dir     (rx_dir),
    .fifo_empty (dma_fifo_empty),
    .hold       (drain_hold)
  );

  logic fly;
  logic link_pend;
  assign link_pend = (|lpend) && !drain_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fly <= 1'b0;
    else        fly <= (fly && !(wr_ok && reg_addr == A_SUM && reg_wdata[SUM_FLY])) || onfly_evt;
  end

  logic [DW-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (reg_addr == A_SUM) begin
      rmux[SUM_LINK] = link_pend;
      rmux[SUM_DMA]  = dpend;
      rmux[SUM_FLY]  = fly;
    end
    if (reg_addr == A_DST) begin
      rmux[DMA_W-1:0] = dstat;
      rmux[DW-1]      = dma_fifo_empty;
    end
    if (reg_addr == A_DEN) rmux[DMA_W-1:0] = den;
    for (int k = 0; k < LINK_REGS; k++) begin
      if (reg_addr == addr_t'(A_LS0 + k))  rmux = lstat[k];
      if (reg_addr == addr_t'(A_LEN0 + k)) rmux = len[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata     <= '0;
      dma_fifo_clr  <= 1'b0;
      link_fifo_clr <= 1'b0;
    end else begin
      reg_rdata     <= rd_ok ? rmux : '0;
      dma_fifo_clr  <= wr_ok && reg_addr == A_DCTL && reg_wdata[DCLR_BIT];
      link_fifo_clr <= wr_ok && reg_addr == A_LCTL && reg_wdata[LCLR_BIT];
    end
  end

  assign irq_n = !(link_pend || dpend || fly);
endmodule

// File: rtl/isc_checker.sv
module isc_checker
  import isc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          onfly_evt,
  input logic          dma_fifo_empty,
  input logic          seq_active,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_n,
  input logic          dma_fifo_clr,
  input logic          link_fifo_clr
);
  a_r2_fly_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    onfly_evt |=> !irq_n);

  a_r4_fifo_empty_live: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !seq_active && reg_addr == A_DST) |=> reg_rdata[DW-1] == $past(dma_fifo_empty));

  a_r7_seq_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && seq_active && reg_addr != A_SUM) |=> reg_rdata == '0);

  a_r9_dma_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dma_fifo_clr |-> $past(reg_wr && !seq_active && reg_addr == A_DCTL && reg_wdata[DCLR_BIT]));

  a_r9_link_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    link_fifo_clr |-> $past(reg_wr && !seq_active && reg_addr == A_LCTL && reg_wdata[LCLR_BIT]));

  a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == '0);
endmodule

bind irq_status_ctrl isc_checker #(.DW(DW)) u_isc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .onfly_evt      (onfly_evt),
  .dma_fifo_empty (dma_fifo_empty),
  .seq_active     (seq_active),
  .reg_rd         (reg_rd),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .irq_n          (irq_n),
  .dma_fifo_clr   (dma_fifo_clr),
  .link_fifo_clr  (link_fifo_clr)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] link_evt = '0;
  logic [6:0]  dma_evt = '0;
  logic        onfly_evt = 1'b0;
  logic        rx_dir = 1'b0;
  logic        dma_fifo_empty = 1'b1;
  logic        seq_active = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_n, dma_fifo_clr, link_fifo_clr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] d;

  always #10 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .link_evt(link_evt), .dma_evt(dma_evt),
    .onfly_evt(onfly_evt), .rx_dir(rx_dir), .dma_fifo_empty(dma_fifo_empty),
    .seq_active(seq_active), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n),
    .dma_fifo_clr(dma_fifo_clr), .link_fifo_clr(link_fifo_clr)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_link(input logic [15:0] v);
    link_evt = v; @(negedge clk); link_evt = '0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 irq_n after reset", irq_n, 1);
    chk("R10 rdata idle", reg_rdata, 0);
    rd(4'd0, d); chk("R10 summary after reset", d, 0);
    rd(4'd4, d); chk("R10 link enable reset", d, 0);

    // R5: enable readback
    wr(4'd4, 8'hA5); rd(4'd4, d); chk("R5 enable readback", d, 8'hA5);

    // R3/R5: every link condition, enabled and masked
    for (int b = 0; b < 16; b++) begin
      for (int m = 0; m < 2; m++) begin
        wr(4'(4 + b / 8), m != 0 ? 8'(1 << (b % 8)) : 8'h00);
        pulse_link(16'(1 << b));
        chk($sformatf("R5 irq link bit %0d en %0d", b, m), irq_n, m == 0);
        rd(4'd0, d); chk($sformatf("R3 summary link bit %0d en %0d", b, m), d, m);
        rd(4'(1 + b / 8), d); chk($sformatf("R3 link read bit %0d", b), d, 1 << (b % 8));
        rd(4'(1 + b / 8), d); chk($sformatf("R3 link cleared bit %0d", b), d, 0);
        chk($sformatf("R3 irq released bit %0d", b), irq_n, 1);
      end
    end

    // R4/R5: every DMA condition, FIFO-empty toggling
    for (int b = 0; b < 7; b++) begin
      for (int m = 0; m < 2; m++) begin
        dma_fifo_empty = (b % 2) == 0;
        wr(4'd6, m != 0 ? 8'(1 << b) : 8'h00);
        dma_evt = 7'(1 << b); @(negedge clk); dma_evt = '0;
        chk($sformatf("R4 irq dma bit %0d en %0d", b, m), irq_n, m == 0);
        rd(4'd0, d); chk($sformatf("R4 summary dma bit %0d", b), d, m * 2);
        rd(4'd3, d); chk($sformatf("R4 dma read bit %0d", b), d, (1 << b) | ((b % 2 == 0) << 7));
        rd(4'd3, d); chk($sformatf("R4 dma cleared, fe kept bit %0d", b), d, (b % 2 == 0) << 7);
      end
    end
    dma_fifo_empty = 1'b1;

    // R1: both groups pending together
    wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd6, 8'h7F);
    link_evt = 16'h0008; dma_evt = 7'h02; @(negedge clk); link_evt = '0; dma_evt = '0;
    rd(4'd0, d); chk("R1 both pending", d, 3);
    chk("R1 irq both", irq_n, 0);
    rd(4'd1, d); rd(4'd0, d); chk("R1 link dropped, dma left", d, 2);
    chk("R1 irq dma only", irq_n, 0);
    rd(4'd3, d); rd(4'd0, d); chk("R1 all clear", d, 0);
    chk("R1 irq idle", irq_n, 1);

    // R2: on-the-fly flag
    onfly_evt = 1'b1; @(negedge clk); onfly_evt = 1'b0;
    chk("R2 irq on fly", irq_n, 0);
    rd(4'd0, d); rd(4'd0, d); chk("R2 survives reads", d, 4);
    wr(4'd0, 8'h03); rd(4'd0, d); chk("R2 write zero keeps", d, 4);
    wr(4'd0, 8'h04); rd(4'd0, d); chk("R2 write one clears", d, 0);
    onfly_evt = 1'b1; wr(4'd0, 8'h04); onfly_evt = 1'b0;
    rd(4'd0, d); chk("R2 event beats clear", d, 4);
    wr(4'd0, 8'h04);

    // R6: event in the same cycle as a clearing read
    pulse_link(16'h0002);
    link_evt = 16'h0001; rd(4'd1, d); link_evt = '0;
    chk("R6 read returns prior", d, 8'h02);
    rd(4'd1, d); chk("R6 new event kept", d, 8'h01);

    // R7: sequencer active
    seq_active = 1'b1;
    pulse_link(16'h0004);
    rd(4'd1, d); chk("R7 blocked read zero", d, 0);
    wr(4'd4, 8'h00);
    wr(4'd7, 8'h04); chk("R7 blocked ctl write", dma_fifo_clr, 0);
    rd(4'd0, d); chk("R7 summary readable", d, 1);
    seq_active = 1'b0;
    rd(4'd4, d); chk("R7 enable write ignored", d, 8'hFF);
    rd(4'd1, d); chk("R7 status not cleared", d, 8'h04);

    // R8: fatal receive event waits for drain
    rx_dir = 1'b1; dma_fifo_empty = 1'b0;
    pulse_link(16'h0001);
    repeat (3) @(negedge clk);
    chk("R8 held irq", irq_n, 1);
    rd(4'd0, d); chk("R8 held summary", d, 0);
    dma_fifo_empty = 1'b1; @(negedge clk);
    chk("R8 released irq", irq_n, 0);
    rd(4'd1, d); chk("R8 status latched", d, 8'h01);
    dma_fifo_empty = 1'b0;
    pulse_link(16'h0020);
    chk("R8 non-fatal immediate", irq_n, 0);
    rd(4'd1, d);
    rx_dir = 1'b0;
    pulse_link(16'h0001);
    chk("R8 send side immediate", irq_n, 0);
    rd(4'd1, d);
    dma_fifo_empty = 1'b1; @(negedge clk);

    // R9: FIFO clear pulses
    wr(4'd7, 8'h04);
    chk("R9 dma clr pulse", dma_fifo_clr, 1);
    chk("R9 link clr quiet", link_fifo_clr, 0);
    @(negedge clk); chk("R9 dma clr self-clears", dma_fifo_clr, 0);
    wr(4'd8, 8'h02);
    chk("R9 link clr pulse", link_fifo_clr, 1);
    @(negedge clk); chk("R9 link clr self-clears", link_fifo_clr, 0);
    wr(4'd7, 8'h02); chk("R9 wrong bit no pulse", dma_fifo_clr, 0);

    report();
  end
endmodule